// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block turns one reader-to-card frame into a timed drive level for a coil. A frame arrives as a data word, a keystream word of the same width and a bit count. The block XORs data and keystream and sends the result least significant bit first. Each bit is a fixed pause, with the coil shorted, followed by an open-coil gap. The length of the gap carries the bit value. After the last bit a bare closing pause, with no gap of its own, ends the frame. The coil is then left open (carrier on).

All timing counts cycles of a tick enable, which the chip runs at 1.5 ticks per microsecond. The defaults are a 30-tick pause (20 us), a 120-tick gap for a one (80 us) and a 60-tick gap for a zero (40 us). These are parameters so that a smaller configuration can be built.

The frame input is a valid/ready stream of one beat per frame. `in_ready` is high only while the block is idle. A beat is taken on a clock where `in_valid` and `in_ready` are both high. A source that raises `in_valid` while the block is busy is back-pressured, and that beat has no effect on the frame in flight. The source must hold the beat's fields stable until it is accepted. `busy`, `done` and `coil` are plain status pins.

Top module: `pp_frame_tx`

## Requirements
- R1: `in_ready` is high exactly when `busy` is low. A beat is accepted on a clock edge with `in_valid` and `in_ready` both high. In the cycle after acceptance, `busy` is 1 and `coil` is 0 (shorted).
- R2: Every bit starts with a pause of PAUSE_T tick-enable cycles with `coil` = 0.
- R3: After the pause, `coil` = 1 (open) for ONE_T tick-enable cycles when the sent bit is 1, and for ZERO_T cycles when it is 0.
- R4: The sent bits are bit 0 upward of `in_data ^ in_key`. Only the low clamped-length bits are sent.
- R5: After the last bit, one more pause of PAUSE_T ticks with `coil` = 0 is sent. `coil` then returns to 1.
- R6: After the closing pause, `busy` stays 1 until the next tick-enable cycle. At that clock edge `busy` falls and `done` rises for exactly one clock.
- R7: A beat offered while `busy` is 1 is ignored. `in_ready` stays 0, and the coil waveform of the current frame is unchanged.
- R8: A length of 0 sends only the closing pause.
- R9: A length above MAX_BITS is treated as MAX_BITS.
- R10: Out of reset and whenever idle, `coil` = 1, `busy` = 0 and `done` = 0.
- R11: In a clock cycle with `tick_en` low, the frame does not advance: `coil` holds and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timing tick enable, one clock wide per tick |
| in_valid | input | 1 | Frame beat valid |
| in_ready | output | 1 | Block idle, ready to accept a frame beat |
| in_data | input | MAX_BITS | Frame data, bit 0 sent first |
| in_key | input | MAX_BITS | Keystream XORed onto the data |
| in_len | input | LEN_W | Bit count of the frame; clamped to MAX_BITS |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at frame completion |
| coil | output | 1 | Coil level: 1 open (carrier on), 0 shorted |

## Verification
The assertions assume the following about the inputs:
- PAUSE_T, ONE_T and ZERO_T are at least 1.
- `tick_en` may follow any pattern.
- A frame beat is offered with stable fields.

From these, they measure pause and gap lengths in ticks by counting tick-enable cycles, and do not depend on clock time. The stimulus presents each beat for one cycle, at a clock edge where the block is idle. It mostly keeps `tick_en` high, so pause and gap lengths can be compared cycle for cycle. It drops `tick_en` only in a stall window and raises `in_valid` during a frame only in the window meant to show that such a beat is ignored.

// File: rtl/pp_tx_pkg.sv
package pp_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_GAP   = 2'd2,
    ST_TAIL  = 2'd3
  } pp_state_t;

  function automatic int unsigned pp_max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pp_word_reg.sv
module pp_word_reg #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                shift,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [MAX_BITS-1:0] key_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic                cur_bit,
  output logic                empty
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BITS);

  logic [MAX_BITS-1:0] word_q;
  logic [LEN_W-1:0]    rem_q;
  logic [LEN_W-1:0]    len_eff;

  always_comb begin
    len_eff = (len_i > LEN_CAP) ? LEN_CAP : len_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      word_q <= data_i ^ key_i;
      rem_q  <= len_eff;
    end else if (shift && (rem_q != '0)) begin
      word_q <= word_q >> 1;
      rem_q  <= rem_q - LEN_W'(1);
    end
  end

  assign cur_bit = word_q[0];
  assign empty   = (rem_q == '0);
endmodule

// File: rtl/pp_tick_timer.sv
module pp_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  assign hit = run && tick && (cnt_q == (limit - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || hit) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pp_tx_fsm.sv
module pp_tx_fsm
  import pp_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic accept,
  input  logic hit,
  input  logic empty,
  output logic load,
  output logic shift,
  output logic run,
  output logic in_pause,
  output logic busy,
  output logic done,
  output logic coil
);
  pp_state_t state_q, state_d;
  logic      done_q;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          load    = 1'b1;
          state_d = ST_PAUSE;
        end
      end
      ST_PAUSE: begin
        if (hit) state_d = empty ? ST_TAIL : ST_GAP;
      end
      ST_GAP: begin
        if (hit) begin
          shift   = 1'b1;
          state_d = ST_PAUSE;
        end
      end
      ST_TAIL: begin
        if (tick) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_TAIL) && tick;
    end
  end

  assign run      = (state_q == ST_PAUSE) || (state_q == ST_GAP);
  assign in_pause = (state_q == ST_PAUSE);
  assign busy     = (state_q != ST_IDLE);
  assign coil     = (state_q != ST_PAUSE);
  assign done     = done_q;
endmodule

// File: rtl/pp_frame_tx.sv
module pp_frame_tx
  import pp_tx_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int PAUSE_T  = 30,
  parameter int ONE_T    = 120,
  parameter int ZERO_T   = 60,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_BITS-1:0] in_data,
  input  logic [MAX_BITS-1:0] in_key,
  input  logic [LEN_W-1:0]    in_len,
  output logic                busy,
  output logic                done,
  output logic                coil
);
  localparam int CNT_W = $clog2(pp_max3(PAUSE_T, ONE_T, ZERO_T) + 1);
  localparam logic [CNT_W-1:0] LIM_PAUSE = CNT_W'(PAUSE_T);
  localparam logic [CNT_W-1:0] LIM_ONE   = CNT_W'(ONE_T);
  localparam logic [CNT_W-1:0] LIM_ZERO  = CNT_W'(ZERO_T);

  logic             accept;
  logic             load;
  logic             shift;
  logic             run;
  logic             in_pause;
  logic             hit;
  logic             cur_bit;
  logic             empty;
  logic             busy_w;
  logic [CNT_W-1:0] limit;

  assign in_ready = !busy_w;
  assign accept   = in_valid && !busy_w;
  assign busy     = busy_w;

  always_comb begin
    if (in_pause)     limit = LIM_PAUSE;
    else if (cur_bit) limit = LIM_ONE;
    else              limit = LIM_ZERO;
  end

  pp_word_reg #(
    .MAX_BITS (MAX_BITS),
    .LEN_W    (LEN_W)
  ) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .shift   (shift),
    .data_i  (in_data),
    .key_i   (in_key),
    .len_i   (in_len),
    .cur_bit (cur_bit),
    .empty   (empty)
  );

  pp_tick_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick_en),
    .limit (limit),
    .hit   (hit)
  );

  pp_tx_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .accept   (accept),
    .hit      (hit),
    .empty    (empty),
    .load     (load),
    .shift    (shift),
    .run      (run),
    .in_pause (in_pause),
    .busy     (busy_w),
    .done     (done),
    .coil     (coil)
  );
endmodule

// File: rtl/pp_frame_tx_chk.sv
module pp_frame_tx_chk #(
  parameter int PAUSE_T = 30,
  parameter int ONE_T   = 120,
  parameter int ZERO_T  = 60
) (
  input logic clk,
  input logic rst_n,
  input logic tick_en,
  input logic in_valid,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic coil
);
  localparam int W = 16;

  logic [W-1:0] pause_cnt;
  logic [W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_cnt <= '0;
      gap_cnt   <= '0;
    end else begin
      pause_cnt <= (busy && !coil) ? pause_cnt + W'(tick_en) : '0;
      gap_cnt   <= (busy && coil)  ? gap_cnt + W'(tick_en)   : '0;
    end
  end

  // R2 and R5: every shorted interval lasts PAUSE_T ticks
  a_r2_pause_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(coil) && busy) |-> (pause_cnt == W'(PAUSE_T)));

  // R3: gap between pauses is either the one or the zero length
  a_r3_gap_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(coil) && $past(busy)) |-> ((gap_cnt == W'(ONE_T)) || (gap_cnt == W'(ZERO_T))));

  // R1: acceptance shorts the coil next cycle
  a_r1_accept_shorts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !coil));

  // R6: done is a single pulse at the end of a busy period
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: idle means coil open
  a_r10_idle_open: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> coil);

  // R11: no tick, no progress
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_en) |=> ($stable(coil) && busy && !done));
endmodule

bind pp_frame_tx pp_frame_tx_chk #(
  .PAUSE_T (PAUSE_T),
  .ONE_T   (ONE_T),
  .ZERO_T  (ZERO_T)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .done     (done),
  .coil     (coil)
);

// File: tb/sim_pp_frame_tx.sv
`timescale 1ns/1ps
module sim_pp_frame_tx;
  localparam int MB    = 8;
  localparam int PT    = 3;
  localparam int OT    = 8;
  localparam int ZT    = 4;
  localparam int LW    = $clog2(MB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [MB-1:0] in_data = '0;
  logic [MB-1:0] in_key = '0;
  logic [LW-1:0] in_len = '0;
  logic          busy;
  logic          done;
  logic          coil;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pp_frame_tx #(
    .MAX_BITS (MB),
    .PAUSE_T  (PT),
    .ONE_T    (OT),
    .ZERO_T   (ZT)
  ) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_key   (in_key),
    .in_len   (in_len),
    .busy     (busy),
    .done     (done),
    .coil     (coil)
  );

  // per-frame comparison state
  int       samp_idx;
  bit       mism;
  logic [3:0] mism_act, mism_exp;
  int       mism_at;
  bit       inject;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {in_ready, busy, done, coil} at this negedge
  task automatic samp(input logic [3:0] exp);
    logic [3:0] act;
    act = {in_ready, busy, done, coil};
    if (act !== exp && !mism) begin
      mism     = 1'b1;
      mism_act = act;
      mism_exp = exp;
      mism_at  = samp_idx;
    end
    samp_idx++;
    if (inject) begin
      in_valid = (samp_idx >= 5 && samp_idx < 11);
      in_data  = ~in_data;
      in_key   = in_key + 8'h35;
      in_len   = LW'(MB);
    end
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [MB-1:0] d, input logic [MB-1:0] k,
                           input int len, input int stall, input bit inj,
                           input string req);
    logic [MB-1:0] w;
    int eff;
    w   = d ^ k;
    eff = (len > MB) ? MB : len;
    mism = 1'b0; samp_idx = 0; mism_at = 0; mism_act = '0; mism_exp = '0;
    @(negedge clk);
    in_data = d; in_key = k; in_len = LW'(len); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    inject = inj;
    if (stall > 0) begin
      tick_en = 1'b0;
      for (int s = 0; s < stall; s++) samp(4'b0100);
      tick_en = 1'b1;
    end
    for (int i = 0; i < eff; i++) begin
      for (int p = 0; p < PT; p++) samp(4'b0100);
      for (int g = 0; g < (w[i] ? OT : ZT); g++) samp(4'b0101);
    end
    for (int p = 0; p < PT; p++) samp(4'b0100);
    samp(4'b0101);
    inject = 1'b0;
    in_valid = 1'b0;
    samp(4'b1011);
    samp(4'b1001);
    check(!mism, req, {24'd0, mism_act, 4'(mism_at)}, {24'd0, mism_exp, 4'(mism_at)});
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    inject = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check({in_ready, busy, done, coil} == 4'b1001, "R10 reset", {in_ready, busy, done, coil}, 4'b1001);
    rst_n = 1'b1;
    @(negedge clk);
    check({in_ready, busy, done, coil} == 4'b1001, "R10 idle", {in_ready, busy, done, coil}, 4'b1001);

    // R1 R2 R3 R4 R5 R6: exhaustive full-length data sweep with varying key
    for (int v = 0; v < 256; v++)
      run_frame(8'(v), 8'(v * 37 + 11), MB, 0, 1'b0, "R1 R2 R3 R4 R5 R6 full sweep");

    // R8 R9 R4: every length including zero and above the cap
    for (int l = 0; l < (1 << LW); l++)
      run_frame(8'hB6, 8'h0F, l, 0, 1'b0, "R4 R8 R9 length sweep");

    // R7: beats offered while busy have no effect
    run_frame(8'h5A, 8'h00, 5, 0, 1'b1, "R7 ignore while busy");

    // R11: no progress without ticks
    run_frame(8'h03, 8'h01, 2, 20, 1'b0, "R11 tick stall");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule